// File: doc/BRIEF.md
# Shaped On/Off Amplitude Keying Controller

This block multiplies a pair of signed sample streams (I and Q) by a 12-bit amplitude factor, so that a transmitted burst can fade in and out instead of switching abruptly. Two control inputs select one of three behaviours. With shaping off, the multipliers are skipped and the samples pass through unchanged. With shaping on and ramp control selected, one internal level counter sets the amplitude for both channels. That counter climbs toward full scale while the keying input is high and falls toward zero while it is low. In the remaining mode, each channel takes its factor from its own user-supplied 12-bit value, which allows any envelope that software or another block can produce.

The speed of the internal ramp comes from an 8-bit reloading divider. The divider counts down once per clock. When it reaches zero it advances the level by one and loads the programmed rate again. A full zero-to-full transition therefore takes 4095 steps of rate+1 clocks each. The level cannot go past either end of its range. Each output is the product of sample and scale, divided by 4096 with the fraction dropped toward minus infinity, and it is registered with one cycle of latency.

Top module: `shaped_keyer`

## Requirements
- R1: While `shape_en` is 0, each output equals its input sample from the previous clock edge (bypass, full scale).
- R2: While `shape_en` is 1 and `ramp_sel` is 1, both channels are scaled by the same internal level.
- R3: While `shape_en` is 1 and `ramp_sel` is 0, `dout_i` is scaled by `user_scale_i` and `dout_q` by `user_scale_q`. A user scale of 0 gives an output of 0.
- R4: With rate value R, once the ramp has been inactive for at least one clock and then becomes active, the level steps on the (R+1)th active clock edge and then every R+1 edges after that. R=0 steps on every edge.
- R5: Each step moves the level by exactly one code.
- R6: In both scaling modes, output = floor(sample × scale / 4096), where sample is a signed 12-bit value and scale is an unsigned 12-bit value. The result appears one clock after the inputs are applied.
- R7: While `key_on` is 1, the level rises and then holds at 4095.
- R8: While `key_on` is 0, the level falls and then holds at 0.
- R9: While the ramp is inactive (`shape_en` or `ramp_sel` is 0), the level holds its value and the divider reloads the rate.
- R10: A synchronous reset clears both outputs and the level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shape_en | input | 1 | 1 enables amplitude scaling, 0 bypasses it |
| ramp_sel | input | 1 | 1 selects the internal ramp, 0 selects the user scales |
| step_rate | input | 8 | Divider reload value R; steps occur every R+1 clocks |
| user_scale_i | input | 12 | User amplitude factor for the I channel |
| user_scale_q | input | 12 | User amplitude factor for the Q channel |
| key_on | input | 1 | Ramp direction: 1 ramps toward full scale, 0 toward zero |
| din_i | input | 12 | Signed I sample |
| din_q | input | 12 | Signed Q sample |
| dout_i | output | 12 | Scaled signed I sample, registered |
| dout_q | output | 12 | Scaled signed Q sample, registered |

## Verification
The hardest states to reach are the two ends of the ramp, because they lie more than four thousand steps from reset. The stimulus sets the rate to zero so that the level moves on every clock. It runs the ramp past 4095 with the key held high, then past 0 with the key held low, and compares the outputs at exact edge counts on the way. The check that the level holds while the ramp is inactive works by parking the block in user mode with the key high for many cycles. On return, the bench expects the very first output to show the old level and the next one to show exactly one step more.

// File: rtl/keyer_pkg.sv
package keyer_pkg;

  typedef enum logic [1:0] {
    AMP_BYPASS = 2'd0,
    AMP_RAMP   = 2'd1,
    AMP_USER   = 2'd2
  } amp_mode_e;

  function automatic amp_mode_e decode_mode(input logic en, input logic ramp);
    if (!en)
      return AMP_BYPASS;
    else if (ramp)
      return AMP_RAMP;
    else
      return AMP_USER;
  endfunction

  // signed sample times unsigned scale, divided by 2**SCL_W (floor)
  function automatic logic signed [11:0] scale_sample12(
      input logic signed [11:0] smp,
      input logic [11:0]        scl);
    logic signed [23:0] prod;
    prod = smp * $signed({1'b0, scl});
    return prod[23:12];
  endfunction

endpackage

// File: rtl/ramp_tick_gen.sv
module ramp_tick_gen #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] reload,
  output logic              tick
);

  logic [RATE_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= reload;
    end else if (!run) begin
      cnt_q <= reload;
    end else if (cnt_q == '0) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/ramp_level_ctr.sv
module ramp_level_ctr #(
  parameter int SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               up,
  output logic [SCALE_W-1:0] level
);

  localparam logic [SCALE_W-1:0] LVL_TOP = {SCALE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (step) begin
      if (up && (level != LVL_TOP))
        level <= level + 1'b1;
      else if (!up && (level != '0))
        level <= level - 1'b1;
    end
  end

endmodule

// File: rtl/amp_scaler.sv
module amp_scaler #(
  parameter int SAMPLE_W = 12,
  parameter int SCALE_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bypass,
  input  logic [SCALE_W-1:0]         scale,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] dout
);

  logic signed [SAMPLE_W-1:0] scaled;

  always_comb begin
    scaled = keyer_pkg::scale_sample12(din, scale);
  end

  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else if (bypass)
      dout <= din;
    else
      dout <= scaled;
  end

endmodule

// File: rtl/shaped_keyer.sv
module shaped_keyer #(
  parameter int SAMPLE_W = 12,
  parameter int SCALE_W  = 12,
  parameter int RATE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shape_en,
  input  logic                       ramp_sel,
  input  logic [RATE_W-1:0]          step_rate,
  input  logic [SCALE_W-1:0]         user_scale_i,
  input  logic [SCALE_W-1:0]         user_scale_q,
  input  logic                       key_on,
  input  logic signed [SAMPLE_W-1:0] din_i,
  input  logic signed [SAMPLE_W-1:0] din_q,
  output logic signed [SAMPLE_W-1:0] dout_i,
  output logic signed [SAMPLE_W-1:0] dout_q
);

  import keyer_pkg::*;

  localparam int NCH = 2;

  amp_mode_e          mode;
  logic               ramp_run;
  logic               step_pulse;
  logic [SCALE_W-1:0] level_q;

  logic [SCALE_W-1:0]         ch_scale [NCH];
  logic signed [SAMPLE_W-1:0] ch_din   [NCH];
  logic signed [SAMPLE_W-1:0] ch_dout  [NCH];

  assign mode     = decode_mode(shape_en, ramp_sel);
  assign ramp_run = (mode == AMP_RAMP);

  ramp_tick_gen #(.RATE_W(RATE_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (ramp_run),
    .reload (step_rate),
    .tick   (step_pulse)
  );

  ramp_level_ctr #(.SCALE_W(SCALE_W)) u_level (
    .clk   (clk),
    .rst   (rst),
    .step  (step_pulse),
    .up    (key_on),
    .level (level_q)
  );

  assign ch_din[0] = din_i;
  assign ch_din[1] = din_q;

  always_comb begin
    ch_scale[0] = (mode == AMP_USER) ? user_scale_i : level_q;
    ch_scale[1] = (mode == AMP_USER) ? user_scale_q : level_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    amp_scaler #(.SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W)) u_scl (
      .clk    (clk),
      .rst    (rst),
      .bypass (mode == AMP_BYPASS),
      .scale  (ch_scale[c]),
      .din    (ch_din[c]),
      .dout   (ch_dout[c])
    );
  end

  assign dout_i = ch_dout[0];
  assign dout_q = ch_dout[1];

endmodule

// File: rtl/shaped_keyer_chk.sv
module shaped_keyer_chk #(
  parameter int SAMPLE_W = 12,
  parameter int SCALE_W  = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       shape_en,
  input logic                       ramp_sel,
  input logic                       key_on,
  input logic [SCALE_W-1:0]         user_scale_i,
  input logic signed [SAMPLE_W-1:0] din_i,
  input logic signed [SAMPLE_W-1:0] din_q,
  input logic signed [SAMPLE_W-1:0] dout_i,
  input logic signed [SAMPLE_W-1:0] dout_q,
  input logic [SCALE_W-1:0]         level
);

  localparam logic [SCALE_W-1:0] LVL_TOP = {SCALE_W{1'b1}};

  logic active;
  assign active = shape_en && ramp_sel;

  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    !shape_en |=> (dout_i == $past(din_i)) && (dout_q == $past(din_q)));

  p_user_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (shape_en && !ramp_sel && user_scale_i == '0) |=> (dout_i == '0));

  p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |->
      ((level == $past(level) + 1'b1) || (level == $past(level) - 1'b1)));

  p_top_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (active && key_on && level == LVL_TOP) |=> (level == LVL_TOP));

  p_floor_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !key_on && level == '0) |=> (level == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(level));

endmodule

bind shaped_keyer shaped_keyer_chk #(.SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .shape_en     (shape_en),
  .ramp_sel     (ramp_sel),
  .key_on       (key_on),
  .user_scale_i (user_scale_i),
  .din_i        (din_i),
  .din_q        (din_q),
  .dout_i       (dout_i),
  .dout_q       (dout_q),
  .level        (level_q)
);

// File: tb/shaped_keyer_test.sv
`timescale 1ns/1ps
module shaped_keyer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shape_en = 1'b0;
  logic ramp_sel = 1'b0;
  logic [7:0] step_rate = 8'd0;
  logic [11:0] user_scale_i = '0;
  logic [11:0] user_scale_q = '0;
  logic key_on = 1'b0;
  logic signed [11:0] din_i = '0;
  logic signed [11:0] din_q = '0;
  logic signed [11:0] dout_i;
  logic signed [11:0] dout_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shaped_keyer uut (
    .clk(clk), .rst(rst), .shape_en(shape_en), .ramp_sel(ramp_sel),
    .step_rate(step_rate), .user_scale_i(user_scale_i), .user_scale_q(user_scale_q),
    .key_on(key_on), .din_i(din_i), .din_q(din_q), .dout_i(dout_i), .dout_q(dout_q)
  );

  function automatic int scl(input int s, input int k);
    return (s * k) >>> 12;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic test_reset;  // R10
    rst = 1'b1;
    edges(3);
    check("R10 dout_i", int'(dout_i), 0);
    check("R10 dout_q", int'(dout_q), 0);
    rst = 1'b0;
  endtask

  task automatic test_bypass;  // R1
    int vals[5] = '{-2048, 2047, 0, -1, 1234};
    shape_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      din_i = 12'(vals[k]);
      din_q = 12'(-vals[k] - 1);
      edges(1);
      check("R1 bypass i", int'(dout_i), vals[k]);
      check("R1 bypass q", int'(dout_q), -vals[k] - 1);
    end
  endtask

  task automatic test_user;  // R3, R6
    int si[4] = '{4095, 0, 1, 3000};
    int sq[4] = '{2048, 4095, 1, 123};
    int di[4] = '{2047, -2048, -2048, -777};
    int dq[4] = '{-2048, 1000, 2047, 555};
    shape_en = 1'b1;
    ramp_sel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      user_scale_i = 12'(si[k]);
      user_scale_q = 12'(sq[k]);
      din_i = 12'(di[k]);
      din_q = 12'(dq[k]);
      edges(1);
      check("R3 R6 user i", int'(dout_i), scl(di[k], si[k]));
      check("R3 R6 user q", int'(dout_q), scl(dq[k], sq[k]));
    end
  endtask

  task automatic test_ramp_up;  // R2, R4, R5
    shape_en = 1'b0;
    step_rate = 8'd3;
    key_on = 1'b1;
    edges(1);
    din_i = 12'sd2047;
    din_q = -12'sd2048;
    shape_en = 1'b1;
    ramp_sel = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      edges(1);
      check("R4 R5 ramp q", int'(dout_q), scl(-2048, (k - 1) / 4));
      check("R2 ramp i", int'(dout_i), scl(2047, (k - 1) / 4));
    end
  endtask

  task automatic test_saturate;  // R7, level is 3 on entry
    shape_en = 1'b0;
    step_rate = 8'd0;
    edges(1);
    shape_en = 1'b1;
    edges(10);
    check("R4 R5 rate0 q", int'(dout_q), scl(-2048, 12));
    edges(4090);
    check("R7 top q", int'(dout_q), scl(-2048, 4095));
    check("R7 top i", int'(dout_i), scl(2047, 4095));
    edges(50);
    check("R7 held q", int'(dout_q), scl(-2048, 4095));
  endtask

  task automatic test_ramp_down;  // R8
    key_on = 1'b0;
    edges(1);
    check("R8 first q", int'(dout_q), scl(-2048, 4095));
    edges(2);
    check("R8 fall q", int'(dout_q), scl(-2048, 4093));
    edges(4097);
    check("R8 floor q", int'(dout_q), 0);
    check("R8 floor i", int'(dout_i), 0);
    edges(20);
    check("R8 held q", int'(dout_q), 0);
  endtask

  task automatic test_hold;  // R9, level is 0 on entry
    ramp_sel = 1'b0;
    user_scale_i = '0;
    user_scale_q = '0;
    key_on = 1'b1;
    edges(30);
    check("R3 zero user q", int'(dout_q), 0);
    ramp_sel = 1'b1;
    edges(1);
    check("R9 held level", int'(dout_q), scl(-2048, 0));
    edges(1);
    check("R9 one step", int'(dout_q), scl(-2048, 1));
    edges(2);
    check("R9 three steps", int'(dout_q), scl(-2048, 3));
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_bypass();
    test_user();
    test_ramp_up();
    test_saturate();
    test_ramp_down();
    test_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule